// File: doc/BRIEF.md
# Dynamic Arithmetic/Logical Shifter

This block is a 32-bit shift unit for the execute stage of a small integer core. It handles two kinds of work. The first is shifts whose distance comes from a register: a signed count value sets the direction, and the operation code chooses whether a right shift fills with the sign bit or with zeros. The second is a group of fixed-distance operations: one-bit shifts and rotates that trade a bit with the condition flag T, and plain logical moves by 2, 8 or 16 places.

The operand, count, operation code and incoming T flag are sampled on every rising clock edge. The shifted word and the new T flag appear on registered outputs one cycle later. Reading and writing the register file is done outside this block.

Top module: `shf_core`

## Requirements
- R1: With op = 0 (arithmetic dynamic) or op = 1 (logical dynamic) and count bit 31 clear, the result is the operand shifted left by count[4:0], with zeros entering at bit 0. Count bits 30..5 have no effect.
- R2: With op 0 or 1, count bit 31 set and count[4:0] non-zero, the result is the operand shifted right by (bitwise inverse of count[4:0]) + 1 places, which equals 32 minus count[4:0].
- R3: With count bit 31 set and count[4:0] zero, op 0 gives 32 copies of operand bit 31 and op 1 gives all zeros.
- R4: In a dynamic right shift, op 0 fills the vacated upper bits with operand bit 31 and op 1 fills them with zeros.
- R5: The one-bit shifts work as follows. Op 2 (logical left) and op 3 (arithmetic left) shift left by one, put zero in bit 0 and load T with the old bit 31. Op 4 (logical right) shifts right by one with zero in bit 31 and loads T with the old bit 0. Op 5 (arithmetic right) does the same but keeps bit 31.
- R6: Op 6 rotates left by one, and the old bit 31 goes to both bit 0 and T. Op 7 rotates right by one, and the old bit 0 goes to both bit 31 and T.
- R7: Op 8 rotates left through T: the old T enters bit 0 and T takes the old bit 31. Op 9 rotates right through T: the old T enters bit 31 and T takes the old bit 0.
- R8: These codes are zero-fill logical shifts by a fixed distance: op 10 left by 2, op 11 right by 2, op 12 left by 8, op 13 right by 8, op 14 left by 16 and op 15 right by 16. Each leaves T out equal to T in.
- R9: For op 0 and op 1, T out equals T in.
- R10: The result and T out change one clock after the inputs are sampled. While the synchronous active-high reset is asserted, both are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (see R1 to R9) |
| operand | input | 32 | Word to be shifted |
| count | input | 32 | Signed shift count for op 0 and op 1 |
| t_in | input | 1 | Current T flag |
| result | output | 32 | Registered shifted word |
| t_out | output | 1 | Registered new T flag |

## Verification
The bench builds the block with its default width of 32, so the count field is five bits wide. At this width, every count from -32 to 31 can be swept for both dynamic variants against several operands, including sign-set and alternating patterns. The sweep covers both edges of the count encoding: the full-width fill at a negative count with a zero low field, and the 31-place right shift at count -31. Additional counts with the upper magnitude bits set confirm that only the sign and the low five bits matter.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [3:0] {
    OP_DSHA  = 4'd0,
    OP_DSHL  = 4'd1,
    OP_SHL1  = 4'd2,
    OP_SAL1  = 4'd3,
    OP_SHR1  = 4'd4,
    OP_SAR1  = 4'd5,
    OP_ROL1  = 4'd6,
    OP_ROR1  = 4'd7,
    OP_ROLT  = 4'd8,
    OP_RORT  = 4'd9,
    OP_SHL2  = 4'd10,
    OP_SHR2  = 4'd11,
    OP_SHL8  = 4'd12,
    OP_SHR8  = 4'd13,
    OP_SHL16 = 4'd14,
    OP_SHR16 = 4'd15
  } shf_op_e;

  function automatic logic is_dynamic(input shf_op_e o);
    return (o == OP_DSHA) || (o == OP_DSHL);
  endfunction
endpackage

// File: rtl/shf_dynamic.sv
// Register-count shifter: sign of count picks direction, low field picks distance.
module shf_dynamic #(
  parameter int W = 32
) (
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] cnt,
  input  logic         arith,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] mag;
  logic [CW-1:0] rmag;
  logic          neg;
  logic          full;
  logic          fill;
  logic          unused_cnt_bits;

  assign mag  = cnt[CW-1:0];
  assign neg  = cnt[W-1];
  assign rmag = CW'(~mag) + CW'(1);
  assign full = (mag == '0);
  assign fill = arith & opnd[W-1];
  assign unused_cnt_bits = ^cnt[W-2:CW];

  always_comb begin
    if (!neg) begin
      res = opnd << mag;
    end else if (full) begin
      res = {W{fill}};
    end else if (arith) begin
      res = W'($signed(opnd) >>> rmag);
    end else begin
      res = opnd >> rmag;
    end
  end
endmodule

// File: rtl/shf_unit.sv
// Fixed-distance shifts, rotates and T-exchanging single-bit operations.
module shf_unit
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  shf_op_e      op,
  input  logic [W-1:0] opnd,
  input  logic         t_in,
  output logic [W-1:0] res,
  output logic         t_out
);
  localparam int MSB = W - 1;

  always_comb begin
    res   = opnd;
    t_out = t_in;
    unique case (op)
      OP_SHL1, OP_SAL1: begin res = {opnd[MSB-1:0], 1'b0};        t_out = opnd[MSB]; end
      OP_SHR1:          begin res = {1'b0, opnd[MSB:1]};           t_out = opnd[0];   end
      OP_SAR1:          begin res = {opnd[MSB], opnd[MSB:1]};      t_out = opnd[0];   end
      OP_ROL1:          begin res = {opnd[MSB-1:0], opnd[MSB]};    t_out = opnd[MSB]; end
      OP_ROR1:          begin res = {opnd[0], opnd[MSB:1]};        t_out = opnd[0];   end
      OP_ROLT:          begin res = {opnd[MSB-1:0], t_in};         t_out = opnd[MSB]; end
      OP_RORT:          begin res = {t_in, opnd[MSB:1]};           t_out = opnd[0];   end
      OP_SHL2:  res = opnd << 2;
      OP_SHR2:  res = opnd >> 2;
      OP_SHL8:  res = opnd << 8;
      OP_SHR8:  res = opnd >> 8;
      OP_SHL16: res = opnd << 16;
      OP_SHR16: res = opnd >> 16;
      default: begin res = opnd; t_out = t_in; end
    endcase
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] count,
  input  logic         t_in,
  output logic [W-1:0] result,
  output logic         t_out
);
  shf_op_e      op_e;
  logic [W-1:0] dyn_res;
  logic [W-1:0] unit_res;
  logic         unit_t;
  logic [W-1:0] res_d;
  logic         t_d;

  assign op_e = shf_op_e'(op);

  shf_dynamic #(.W(W)) u_dyn (
    .opnd  (operand),
    .cnt   (count),
    .arith (op_e == OP_DSHA),
    .res   (dyn_res)
  );

  shf_unit #(.W(W)) u_unit (
    .op    (op_e),
    .opnd  (operand),
    .t_in  (t_in),
    .res   (unit_res),
    .t_out (unit_t)
  );

  always_comb begin
    if (is_dynamic(op_e)) begin
      res_d = dyn_res;
      t_d   = t_in;
    end else begin
      res_d = unit_res;
      t_d   = unit_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      t_out  <= 1'b0;
    end else begin
      result <= res_d;
      t_out  <= t_d;
    end
  end
endmodule

// File: rtl/shf_core_chk.sv
module shf_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic [W-1:0] operand,
  input logic [W-1:0] count,
  input logic         t_in,
  input logic [W-1:0] result,
  input logic         t_out
);
  localparam int CW = $clog2(W);

  logic unused_chk;
  assign unused_chk = ^count[W-2:CW];

  // R10
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0) && !t_out);

  // R9
  a_r9_dyn_keeps_t: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op == 4'd1) |=> t_out == $past(t_in));

  // R8
  a_r8_fixed_keeps_t: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd10) |=> t_out == $past(t_in));

  // R3
  a_r3_full_logical_zero: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd1 && count[W-1] && count[CW-1:0] == '0) |=> result == '0);

  // R3
  a_r3_full_arith_sign: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 && count[W-1] && count[CW-1:0] == '0)
      |=> ($countones(result) == 0 || $countones(result) == W));

  // R1
  a_r1_zero_count_identity: assert property (@(posedge clk) disable iff (rst)
    ((op == 4'd0 || op == 4'd1) && !count[W-1] && count[CW-1:0] == '0)
      |=> result == $past(operand));

  // R6
  a_r6_rol_bit: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd6) |=> (result[0] == $past(operand[W-1])) && (t_out == $past(operand[W-1])));

  // R7
  a_r7_rort_bits: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd9) |=> (result[W-1] == $past(t_in)) && (t_out == $past(operand[0])));

  // R5
  a_r5_sar_keeps_sign: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd5) |=> result[W-1] == $past(operand[W-1]));
endmodule

bind shf_core shf_core_chk #(.W(W)) u_chk (.*);

// File: tb/shf_core_bench.sv
`timescale 1ns/1ps
module shf_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'd0;
  logic [31:0] operand = '0;
  logic [31:0] count = '0;
  logic        t_in = 1'b0;
  logic [31:0] result;
  logic        t_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shf_core u_shf_core (
    .clk(clk), .rst(rst), .op(op), .operand(operand),
    .count(count), .t_in(t_in), .result(result), .t_out(t_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] c, input logic t);
    @(negedge clk);
    op = o; operand = a; count = c; t_in = t;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] ref_dyn(input bit arith, input logic [31:0] a,
                                          input logic [31:0] c);
    logic [31:0] r;
    int n;
    if (!c[31]) return a << c[4:0];
    n = (c[4:0] == 5'd0) ? 32 : 32 - int'(c[4:0]);
    for (int i = 0; i < 32; i++)
      r[i] = (i + n < 32) ? a[i + n] : (arith ? a[31] : 1'b0);
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    op = 4'd6; operand = 32'hFFFF_FFFF; t_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset result", result, 32'h0);
    check("R10 reset t", {31'b0, t_out}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_dyn_sweep();
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hC3A5_0F96};
    for (int p = 0; p < 3; p++) begin
      for (int k = -32; k <= 31; k++) begin
        for (int v = 0; v < 2; v++) begin
          logic [31:0] c;
          logic tt;
          c  = 32'(k);
          tt = logic'((k + p) & 1);
          apply(4'(v), pats[p], c, tt);
          if (k >= 0)                check("R1 dyn left", result, ref_dyn(v == 0, pats[p], c));
          else if (c[4:0] != 5'd0)   check(v == 0 ? "R2 R4 arith right" : "R2 R4 logical right",
                                           result, ref_dyn(v == 0, pats[p], c));
          else                       check("R3 full shift", result, ref_dyn(v == 0, pats[p], c));
          check("R9 dyn T kept", {31'b0, t_out}, {31'b0, tt});
        end
      end
    end
  endtask

  task automatic t_dyn_edges();
    // R1: upper count bits ignored
    apply(4'd1, 32'h0000_00F1, 32'h0000_0045, 1'b0);
    check("R1 high bits ignored", result, 32'h0000_1E20);
    apply(4'd0, 32'hDEAD_BEEF, 32'h7FFF_FFE0, 1'b1);
    check("R1 zero low field", result, 32'hDEAD_BEEF);
    // R2: -31 encoded with extra magnitude bits
    apply(4'd0, 32'h8000_0000, 32'h8000_0001, 1'b0);
    check("R2 R4 arith right 31", result, 32'hFFFF_FFFF);
    apply(4'd1, 32'h8000_0000, 32'h8000_0001, 1'b0);
    check("R2 R4 logical right 31", result, 32'h0000_0001);
    // R3: negative, zero low field
    apply(4'd0, 32'h9000_0000, 32'hFFFF_FF00, 1'b0);
    check("R3 arith full sign", result, 32'hFFFF_FFFF);
    apply(4'd0, 32'h7FFF_FFFF, 32'hFFFF_FF00, 1'b0);
    check("R3 arith full positive", result, 32'h0000_0000);
    apply(4'd1, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1);
    check("R3 logical full zero", result, 32'h0000_0000);
  endtask

  task automatic t_one_bit();
    logic [31:0] pats [3] = '{32'h8000_0001, 32'h4000_0002, 32'hA5A5_5A5A};
    for (int p = 0; p < 3; p++) begin
      for (int tv = 0; tv < 2; tv++) begin
        logic [31:0] a;
        logic tt;
        a = pats[p];
        tt = logic'(tv);
        apply(4'd2, a, '0, tt);
        check("R5 shl1", result, {a[30:0], 1'b0});  check("R5 shl1 T", {31'b0, t_out}, {31'b0, a[31]});
        apply(4'd3, a, '0, tt);
        check("R5 sal1", result, {a[30:0], 1'b0});  check("R5 sal1 T", {31'b0, t_out}, {31'b0, a[31]});
        apply(4'd4, a, '0, tt);
        check("R5 shr1", result, {1'b0, a[31:1]});  check("R5 shr1 T", {31'b0, t_out}, {31'b0, a[0]});
        apply(4'd5, a, '0, tt);
        check("R5 sar1", result, {a[31], a[31:1]}); check("R5 sar1 T", {31'b0, t_out}, {31'b0, a[0]});
        apply(4'd6, a, '0, tt);
        check("R6 rol", result, {a[30:0], a[31]});  check("R6 rol T", {31'b0, t_out}, {31'b0, a[31]});
        apply(4'd7, a, '0, tt);
        check("R6 ror", result, {a[0], a[31:1]});   check("R6 ror T", {31'b0, t_out}, {31'b0, a[0]});
        apply(4'd8, a, '0, tt);
        check("R7 rolt", result, {a[30:0], tt});    check("R7 rolt T", {31'b0, t_out}, {31'b0, a[31]});
        apply(4'd9, a, '0, tt);
        check("R7 rort", result, {tt, a[31:1]});    check("R7 rort T", {31'b0, t_out}, {31'b0, a[0]});
      end
    end
  endtask

  task automatic t_fixed();
    logic [31:0] a;
    a = 32'hF00D_C0DE;
    for (int tv = 0; tv < 2; tv++) begin
      logic tt;
      tt = logic'(tv);
      apply(4'd10, a, 32'hFFFF_FFFF, tt); check("R8 shl2", result, a << 2);
      check("R8 shl2 T", {31'b0, t_out}, {31'b0, tt});
      apply(4'd11, a, 32'hFFFF_FFFF, tt); check("R8 shr2", result, a >> 2);
      check("R8 shr2 T", {31'b0, t_out}, {31'b0, tt});
      apply(4'd12, a, '0, tt); check("R8 shl8", result, 32'h0DC0_DE00);
      check("R8 shl8 T", {31'b0, t_out}, {31'b0, tt});
      apply(4'd13, a, '0, tt); check("R8 shr8", result, 32'h00F0_0DC0);
      check("R8 shr8 T", {31'b0, t_out}, {31'b0, tt});
      apply(4'd14, a, '0, tt); check("R8 shl16", result, 32'hC0DE_0000);
      check("R8 shl16 T", {31'b0, t_out}, {31'b0, tt});
      apply(4'd15, a, '0, tt); check("R8 shr16", result, 32'h0000_F00D);
      check("R8 shr16 T", {31'b0, t_out}, {31'b0, tt});
    end
  endtask

  task automatic t_latency();
    // R10: output holds the previous cycle's result until the next edge
    apply(4'd14, 32'h0000_1234, '0, 1'b0);
    @(negedge clk);
    op = 4'd15; operand = 32'hABCD_0000;
    #1;
    check("R10 registered hold", result, 32'h1234_0000);
    @(posedge clk);
    #1;
    check("R10 one cycle update", result, 32'h0000_ABCD);
  endtask

  initial begin
    t_reset();
    t_dyn_sweep();
    t_dyn_edges();
    t_one_bit();
    t_fixed();
    t_latency();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule